// File: doc/BRIEF.md
# DMA Channel Request and Transfer-Count Controller

One channel of a DMA sequencer. The block watches an active-low external request line, chosen from a small set of request inputs, and turns each accepted request into bus-cycle requests. It pulses an acknowledge strobe during every counted transfer and decrements a programmable count register. When the count runs out it raises a sticky end flag and turns itself off. Addresses, data and arbitration between channels are handled elsewhere.

The request line is resynchronised with two flops. It is then read either as a level (low means request) or as a falling edge, depending on a control bit. In cycle-steal mode the channel gives up the bus after every transfer. In burst mode it keeps the bus until the count is used up. When burst mode is combined with edge detection, the first bus cycle is a dummy: it is neither acknowledged nor counted. A written count of zero stands for 65,536 transfers.

The bus side is a valid/ready pair. `bus_req` acts as valid and `bus_gnt` as ready. A bus cycle completes on each clock where both are high. Once `bus_req` rises it is never withdrawn before a grant, so the arbiter may stall it for any number of cycles.

Registers are selected by `reg_addr`. Address 0 is the count register: bits [15:0] hold the count and bits [31:16] read as zero. Address 1 is the control register, with these bits:

- bit 0: enable
- bit 1: edge mode (1 = edge, 0 = level)
- bit 2: burst mode (1 = burst, 0 = cycle steal)
- bit 3: request-line select
- bit 8: end flag, cleared by writing 1

Top module: `dmac_chan`

## Requirements
- R1: In level mode (control bit 1 = 0), an enabled channel starts a transfer whenever the synchronised selected request is low. A request held low keeps starting further transfers until the count ends.
- R2: In edge mode (control bit 1 = 1), only a high-to-low transition of the selected request starts a transfer. A line held low after its edge starts nothing more.
- R3: A written count of 1 gives exactly one acknowledged transfer. A written count of 0 gives exactly 65,536.
- R4: Reading address 0 returns the count in bits [15:0] and zero in bits [31:16]. Writes to bits [31:16] are ignored. While the channel runs, the read value is the number of transfers still to do.
- R5: `dack` is high for exactly one clock per counted bus cycle, only when `bus_req` and `bus_gnt` are both high. Each such cycle lowers the count by one.
- R6: With burst and edge mode both set (control bits 2 and 1 = 1), the first completed bus cycle after a start is a dummy. It has no `dack` and leaves the count unchanged.
- R7: In burst mode (control bit 2 = 1), `bus_req` stays high without a break from start until the last transfer. Level-mode burst has no dummy cycle.
- R8: In cycle-steal mode (control bit 2 = 0), `bus_req` goes low for at least one clock after every counted transfer.
- R9: When the last transfer completes, the end flag (`done`, control bit 8) is set and the enable bit is cleared. The flag stays set until a control write with bit 8 = 1.
- R10: Control bit 3 selects the request line: 0 selects `dreq_n[0]`, 1 selects `dreq_n[1]`. The other line has no effect.
- R11: Once raised, `bus_req` stays high until a cycle with `bus_gnt` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = count, 1 = control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| dreq_n | input | 2 | Active-low external request lines |
| bus_req | output | 1 | Bus-cycle request (valid) |
| bus_gnt | input | 1 | Bus-cycle grant (ready) |
| dack | output | 1 | Transfer acknowledge, one clock per counted cycle |
| done | output | 1 | Sticky transfer-end flag |

## Verification
The sequencer is driven with four pairings of trigger and mode:

- Level-mode cycle steal with the request held low. This must retrigger.
- Edge-mode cycle steal with a long low pulse followed by fresh edges. This separates edge sensing from level sensing.
- Edge-mode burst under a stuttering grant. This shows the single uncounted dummy cycle and the unbroken request.
- Level-mode burst. This has no dummy, and is run at counts of 1 and 0 (65,536).

A run with the unselected line low shows that line-select works. A long grant stall shows that the request is held.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BUS  = 2'd1,
    SQ_GAP  = 2'd2
  } sq_state_t;

  localparam int CTL_EN    = 0;
  localparam int CTL_EDGE  = 1;
  localparam int CTL_BURST = 2;
  localparam int CTL_SEL   = 3;
  localparam int CTL_DONE  = 8;

  localparam logic ADDR_COUNT = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;
endpackage

// File: rtl/dmac_req_front.sv
module dmac_req_front #(
  parameter int NREQ = 2,
  parameter int SELW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] dreq_n,
  input  logic [SELW-1:0] sel,
  output logic            lvl_act,
  output logic            fall
);
  logic [NREQ-1:0] meta_q;
  logic [NREQ-1:0] sync_q;
  logic            prev_q;
  logic            cur;

  // two-flop synchroniser per request line
  for (genvar g = 0; g < NREQ; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b1;
        sync_q[g] <= 1'b1;
      end else begin
        meta_q[g] <= dreq_n[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign cur = (int'(sel) < NREQ) ? sync_q[sel] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= cur;
  end

  assign lvl_act = ~cur;
  assign fall    = prev_q & ~cur;
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SELW  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             dec,
  input  logic             xfer_end,
  output logic [CNT_W-1:0] cnt_q,
  output logic             en_q,
  output logic             edge_q,
  output logic             burst_q,
  output logic [SELW-1:0]  sel_q,
  output logic             done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (reg_wr && reg_addr == ADDR_COUNT) begin
      cnt_q <= reg_wdata[CNT_W-1:0];
    end else if (dec) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      edge_q  <= 1'b0;
      burst_q <= 1'b0;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) begin
        en_q    <= reg_wdata[CTL_EN];
        edge_q  <= reg_wdata[CTL_EDGE];
        burst_q <= reg_wdata[CTL_BURST];
        sel_q   <= reg_wdata[CTL_SEL +: SELW];
        if (reg_wdata[CTL_DONE]) done_q <= 1'b0;
      end
      if (xfer_end) begin
        en_q   <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_COUNT) begin
      reg_rdata[CNT_W-1:0] = cnt_q;
    end else begin
      reg_rdata[CTL_EN]             = en_q;
      reg_rdata[CTL_EDGE]           = edge_q;
      reg_rdata[CTL_BURST]          = burst_q;
      reg_rdata[CTL_SEL +: SELW]    = sel_q;
      reg_rdata[CTL_DONE]           = done_q;
    end
  end
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic edge_mode,
  input  logic burst,
  input  logic lvl_act,
  input  logic fall,
  input  logic cnt_is_one,
  input  logic bus_gnt,
  output logic bus_req,
  output logic dack,
  output logic dec,
  output logic xfer_end,
  output logic dummy_q
);
  sq_state_t st_q, st_d;
  logic pend_q;
  logic req_hit, start, xfer;

  assign req_hit  = edge_mode ? (pend_q | fall) : lvl_act;
  assign start    = (st_q == SQ_IDLE) && en && req_hit;
  assign bus_req  = (st_q == SQ_BUS);
  assign xfer     = bus_req && bus_gnt;
  assign dack     = xfer && !dummy_q;
  assign dec      = dack;
  assign xfer_end = dack && cnt_is_one;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: if (start) st_d = SQ_BUS;
      SQ_BUS: begin
        if (dack) begin
          if (cnt_is_one) st_d = SQ_IDLE;
          else if (!burst) st_d = SQ_GAP;
        end
      end
      SQ_GAP:  st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      dummy_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start)     dummy_q <= burst && edge_mode;
      else if (xfer) dummy_q <= 1'b0;
      if (!en || start) pend_q <= 1'b0;
      else if (fall)    pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan #(
  parameter int NREQ  = 2,
  parameter int CNT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NREQ-1:0] dreq_n,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic            dack,
  output logic            done
);
  localparam int SELW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             en_q, edge_q, burst_q, done_q;
  logic [SELW-1:0]  sel_q;
  logic             lvl_act, fall, dec, xfer_end, dummy_q;

  dmac_req_front #(.NREQ(NREQ), .SELW(SELW)) front_i (
    .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .sel(sel_q),
    .lvl_act(lvl_act), .fall(fall)
  );

  dmac_regs #(.CNT_W(CNT_W), .SELW(SELW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec(dec),
    .xfer_end(xfer_end), .cnt_q(cnt_q), .en_q(en_q), .edge_q(edge_q),
    .burst_q(burst_q), .sel_q(sel_q), .done_q(done_q)
  );

  dmac_seq seq_i (
    .clk(clk), .rst_n(rst_n), .en(en_q), .edge_mode(edge_q),
    .burst(burst_q), .lvl_act(lvl_act), .fall(fall),
    .cnt_is_one(cnt_q == CNT_W'(1)), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .dack(dack), .dec(dec), .xfer_end(xfer_end),
    .dummy_q(dummy_q)
  );

  assign done = done_q;
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             dack,
  input logic             done,
  input logic [CNT_W-1:0] cnt,
  input logic             burst,
  input logic             en,
  input logic             dummy
);
  a_r5_dack_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (bus_req && bus_gnt));

  a_r5_dack_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    dack |=> (cnt == $past(cnt) - 1'b1));

  a_r6_dummy_no_dack: assert property (@(posedge clk) disable iff (!rst_n)
    (dummy && bus_req && bus_gnt) |-> !dack);

  a_r6_dummy_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (dummy && bus_req && bus_gnt) |=> $stable(cnt));

  a_r7_burst_holds_req: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && burst && !(dack && cnt == CNT_W'(1))) |=> bus_req);

  a_r8_steal_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && !burst) |=> !bus_req);

  a_r9_end_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !en);

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);
endmodule

bind dmac_chan dmac_chan_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .dack(dack), .done(done), .cnt(cnt_q), .burst(burst_q), .en(en_q),
  .dummy(dummy_q)
);

// File: tb/dmac_chan_tb.sv
`timescale 1ns/1ps
module dmac_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  dreq_n = 2'b11;
  logic        bus_req;
  logic        bus_gnt = 1'b1;
  logic        dack;
  logic        done;

  int checks = 0;
  int failures = 0;
  int n_cyc, n_dack, n_dummy, n_fall;
  logic prev_req = 1'b0;
  logic first_seen;
  logic first_dack;

  always #2.5 clk = ~clk;

  dmac_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq_n(dreq_n),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .dack(dack), .done(done)
  );

  // monitor: one sample per clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && bus_gnt) begin
        n_cyc++;
        if (!dack) n_dummy++;
        if (!first_seen) begin
          first_seen = 1'b1;
          first_dack = dack;
        end
      end
      if (dack) n_dack++;
      if (prev_req && !bus_req) n_fall++;
      prev_req = bus_req;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_cyc = 0; n_dack = 0; n_dummy = 0; n_fall = 0;
    first_seen = 1'b0; first_dack = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input int lim, input string tag);
    int k = 0;
    while (!done && k < lim) begin @(negedge clk); k++; end
    chk(done === 1'b1, tag, done, 1);
    idle(3);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(1'b0, d); chk(d == 0, "R4 reset count", d, 0);
    rd(1'b1, d); chk(d == 0, "R9 reset control", d, 0);
    chk(!bus_req && !dack && !done, "R11 reset outputs", {bus_req, dack, done}, 0);
  endtask

  task automatic t_count_reg();
    logic [31:0] d;
    wr(1'b0, 32'hABCD_1234);
    rd(1'b0, d); chk(d == 32'h0000_1234, "R4 upper bits ignored", d, 32'h1234);
  endtask

  task automatic t_level_steal();
    logic [31:0] d;
    dreq_n = 2'b11; bus_gnt = 1'b1; idle(4);
    wr(1'b0, 3); clr_mon();
    wr(1'b1, 32'h1);           // enable, level, steal, line 0
    dreq_n = 2'b10;
    wait_done(200, "R9 level steal done");
    chk(n_dack == 3, "R1 level retrigger dack", n_dack, 3);
    chk(n_dummy == 0, "R1 no dummy in steal", n_dummy, 0);
    chk(n_fall == 3, "R8 release after each", n_fall, 3);
    rd(1'b1, d); chk(d[0] == 1'b0, "R9 enable cleared", d[0], 0);
    rd(1'b0, d); chk(d == 0, "R4 count at end", d, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(1'b1, 32'h0);
    chk(done == 1'b1, "R9 flag sticky", done, 1);
    wr(1'b1, 32'h100);
    chk(done == 1'b0, "R9 write-one clears", done, 0);
    dreq_n = 2'b11; idle(4);
    rd(1'b1, d); chk(d == 0, "R9 control after clear", d, 0);
  endtask

  task automatic t_edge_steal();
    logic [31:0] d;
    dreq_n = 2'b11; bus_gnt = 1'b1; idle(5);
    wr(1'b0, 3); clr_mon();
    wr(1'b1, 32'h3);           // enable, edge, steal
    dreq_n = 2'b10; idle(40);
    chk(n_dack == 1, "R2 held low one transfer", n_dack, 1);
    rd(1'b0, d); chk(d == 2, "R4 remaining while running", d, 2);
    for (int p = 0; p < 2; p++) begin
      dreq_n = 2'b11; idle(6);
      dreq_n = 2'b10; idle(12);
    end
    wait_done(100, "R2 edge steal done");
    chk(n_dack == 3, "R2 one per edge", n_dack, 3);
    wr(1'b1, 32'h100);
  endtask

  task automatic t_burst_edge();
    int k;
    dreq_n = 2'b11; idle(5);
    wr(1'b0, 4); clr_mon();
    wr(1'b1, 32'h7);           // enable, edge, burst
    dreq_n = 2'b10;
    k = 0;
    while (!done && k < 300) begin
      @(negedge clk);
      bus_gnt = (k % 3) != 0;
      k++;
    end
    bus_gnt = 1'b1;
    chk(done == 1'b1, "R9 burst edge done", done, 1);
    idle(3);
    chk(n_cyc == 5, "R6 bus cycles incl dummy", n_cyc, 5);
    chk(n_dack == 4, "R6 counted transfers", n_dack, 4);
    chk(n_dummy == 1, "R6 one dummy", n_dummy, 1);
    chk(first_dack == 1'b0, "R6 first cycle no dack", first_dack, 0);
    chk(n_fall == 1, "R7 request unbroken", n_fall, 1);
    wr(1'b1, 32'h100);
  endtask

  task automatic t_burst_level(input logic [15:0] cnt, input int exp, input string tag);
    dreq_n = 2'b11; idle(4);
    wr(1'b0, {16'h0, cnt}); clr_mon();
    wr(1'b1, 32'h5);           // enable, level, burst
    dreq_n = 2'b10;
    wait_done(exp + 50, tag);
    chk(n_dack == exp, tag, n_dack, exp);
    chk(n_dummy == 0, "R7 level burst no dummy", n_dummy, 0);
    chk(n_fall == 1, "R7 level burst unbroken", n_fall, 1);
    wr(1'b1, 32'h100);
  endtask

  task automatic t_select();
    logic [31:0] d;
    dreq_n = 2'b11; idle(4);
    wr(1'b0, 2); clr_mon();
    wr(1'b1, 32'h9);           // enable, level, steal, line 1
    dreq_n = 2'b10; idle(20);  // only unselected line low
    chk(n_cyc == 0, "R10 other line ignored", n_cyc, 0);
    rd(1'b0, d); chk(d == 2, "R10 count untouched", d, 2);
    dreq_n = 2'b01;
    wait_done(200, "R10 selected line done");
    chk(n_dack == 2, "R10 selected line transfers", n_dack, 2);
    wr(1'b1, 32'h100);
  endtask

  task automatic t_stall();
    int k;
    dreq_n = 2'b11; idle(4);
    wr(1'b0, 1); clr_mon();
    bus_gnt = 1'b0;
    wr(1'b1, 32'h1);
    dreq_n = 2'b10;
    k = 0;
    while (!bus_req && k < 50) begin @(negedge clk); k++; end
    for (int i = 0; i < 6; i++) begin
      chk(bus_req == 1'b1 && dack == 1'b0, "R11 request held in stall", bus_req, 1);
      @(negedge clk);
    end
    bus_gnt = 1'b1;
    wait_done(50, "R11 stall done");
    chk(n_dack == 1, "R3 count one single transfer", n_dack, 1);
    wr(1'b1, 32'h100);
  endtask

  initial begin : watchdog
    #(5.0 * 190000);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clr_mon();
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_count_reg();
    t_level_steal();
    t_w1c();
    t_edge_steal();
    t_burst_edge();
    t_burst_level(16'd1, 1, "R3 count one burst");
    t_burst_level(16'd2, 2, "R1 level burst two");
    t_select();
    t_stall();
    t_burst_level(16'd0, 65536, "R3 zero means 65536");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule